// File: doc/BRIEF.md
# Prescaled Dual Stall Timeout Timers

This block watches two sides of a data-moving channel, the memory side and the stream side, and raises a flag when either side has made no progress for too long. A single programmable prescaler divides the clock into a tick. Both idle counters advance on that tick. Each counter returns to zero whenever its own side reports progress through a one-cycle activity strobe. When a counter has seen more idle ticks than the programmed limit allows, it expires: its flag is set and the counter starts over.

The flags are sticky. They stay set until the surrounding logic pulses the clear input, so an expiry is never missed between polls. One enable bit turns both timers on or off. When the limit field holds the reserved all-ones code, both counters are forced to zero and neither can expire. Software can use this code to restart both timers without touching the enable bit.

Top module: `stall_watch_timers`

## Requirements
- R1: After reset both timeout flags are 0.
- R2: With prescaler value P, the tick occurs on every (P+1)-th enabled clock cycle. The first tick falls on the (P+1)-th edge after the enable is seen high. This holds for P=0 (every cycle) up to P=0xFFF (every 4096 cycles).
- R3: With limit L (0x000 to 0xFFE) and no activity, a counter expires on the (L+1)-th tick after it last restarted. Its flag reads 1 after that edge and 0 before it. Both channels time out independently of each other.
- R4: An activity strobe restarts only its own channel's counter. It takes priority over a tick in the same cycle, so that cycle cannot expire.
- R5: A set flag stays 1 until flag_clr is high at a clock edge; the flag then reads 0 after that edge. If an expiry falls in the same cycle as the clear, the expiry wins.
- R6: While the enable is 0, both counters and the prescaler are held at zero and no flag can become set.
- R7: The prescaler restarts from zero whenever the enable is low. A re-enabled timer therefore takes the full (L+1)(P+1) edges to expire, whatever the prescaler phase was before.
- R8: The limit code 0xFFF clears both counters and keeps them at zero, so no expiry happens while it is applied.
- R9: A counter whose count is already at or above a newly lowered limit expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Enables prescaler and both counters |
| presc_val | input | 12 | Prescaler value P; tick every P+1 cycles |
| limit_val | input | 12 | Idle limit L; 0xFFF clears both counters |
| mem_act | input | 1 | Memory-side progress strobe |
| strm_act | input | 1 | Stream-side progress strobe |
| flag_clr | input | 1 | Clears both sticky flags |
| mem_timeout | output | 1 | Sticky memory-side timeout flag |
| strm_timeout | output | 1 | Sticky stream-side timeout flag |

## Verification
Several rules are checked by assertions on every cycle:
- The tick never fires while disabled and is never back-to-back unless P is zero.
- A flag rises only in the cycle after a tick.
- A flag never rises right after its own activity strobe.
- A flag holds until cleared.
- Nothing sets while disabled or while the reserved code is applied.

Exact expiry timing can only be shown by the directed scenarios: the (L+1)(P+1) edge count, the prescaler restart on re-enable, the counter reset by the reserved code, and expiry after a lowered limit.

// File: rtl/stw_pkg.sv
package stw_pkg;
   localparam int unsigned NUM_CH = 2;

   typedef enum int unsigned {
      CH_MEM  = 0,
      CH_STRM = 1
   } stw_chan_e;

   function automatic int unsigned stw_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/stw_prescaler.sv
module stw_prescaler #(
   parameter int unsigned DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] phase_q;

   // Compare with >= so a lowered divider cannot strand the phase above it.
   assign tick = en && (phase_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!en || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/stw_idle_counter.sv
module stw_idle_counter #(
   parameter int unsigned CNT_W    = 12,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             act,
   input  logic [CNT_W-1:0] limit,
   input  logic             clr,
   output logic             flag
);
   logic [CNT_W-1:0] idle_q;
   logic             expire;
   logic             flag_d;

   assign expire = run && tick && !act && (idle_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= '0;
      end else if (!run || act || expire) begin
         idle_q <= '0;
      end else if (tick) begin
         idle_q <= idle_q + 1'b1;
      end
   end

   generate
      if (SET_WINS) begin : g_set_wins
         assign flag_d = expire | (flag & ~clr);
      end else begin : g_clr_wins
         assign flag_d = ~clr & (flag | expire);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_d;
   end
endmodule

// File: rtl/stall_watch_timers.sv
module stall_watch_timers #(
   parameter int unsigned PRESC_W  = 12,
   parameter int unsigned LIMIT_W  = 12,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tmr_en,
   input  logic [PRESC_W-1:0] presc_val,
   input  logic [LIMIT_W-1:0] limit_val,
   input  logic               mem_act,
   input  logic               strm_act,
   input  logic               flag_clr,
   output logic               mem_timeout,
   output logic               strm_timeout
);
   import stw_pkg::*;

   localparam logic [LIMIT_W-1:0] LIMIT_CODE = {LIMIT_W{1'b1}};

   generate
      if (PRESC_W < 1 || LIMIT_W < 2) begin : g_bad_width
         $error("stall_watch_timers: PRESC_W must be >=1 and LIMIT_W >=2");
      end
      if (NUM_CH != 2) begin : g_bad_ch
         $error("stall_watch_timers: exactly two channels are mapped to ports");
      end
   endgenerate

   logic              tick;
   logic              run;
   logic [NUM_CH-1:0] act_vec;
   logic [NUM_CH-1:0] flag_vec;

   assign run = tmr_en && (limit_val != LIMIT_CODE);

   assign act_vec[CH_MEM]  = mem_act;
   assign act_vec[CH_STRM] = strm_act;

   stw_prescaler #(.DIV_W(PRESC_W)) presc_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tmr_en),
      .div  (presc_val),
      .tick (tick)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         stw_idle_counter #(.CNT_W(LIMIT_W), .SET_WINS(SET_WINS)) cnt_i (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run),
            .tick (tick),
            .act  (act_vec[c]),
            .limit(limit_val),
            .clr  (flag_clr),
            .flag (flag_vec[c])
         );
      end
   endgenerate

   assign mem_timeout  = flag_vec[CH_MEM];
   assign strm_timeout = flag_vec[CH_STRM];
endmodule

// File: rtl/stw_checker.sv
module stw_checker #(
   parameter int unsigned PRESC_W = 12,
   parameter int unsigned LIMIT_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tmr_en,
   input logic [PRESC_W-1:0] presc_val,
   input logic [LIMIT_W-1:0] limit_val,
   input logic               mem_act,
   input logic               strm_act,
   input logic               flag_clr,
   input logic               mem_timeout,
   input logic               strm_timeout,
   input logic               tick
);
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || presc_val == '0)); // R2
   AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |-> !tick); // R6
   AST_MEM_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_timeout) |-> $past(tick)); // R3
   AST_STRM_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strm_timeout) |-> $past(tick)); // R3
   AST_MEM_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_act |=> !$rose(mem_timeout)); // R4
   AST_STRM_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      strm_act |=> !$rose(strm_timeout)); // R4
   AST_MEM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_timeout && !flag_clr) |=> mem_timeout); // R5
   AST_STRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (strm_timeout && !flag_clr) |=> strm_timeout); // R5
   AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && !mem_timeout && !strm_timeout) |=> (!mem_timeout && !strm_timeout)); // R6
   AST_CODE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_val == '1 && !mem_timeout && !strm_timeout) |=> (!mem_timeout && !strm_timeout)); // R8
endmodule

bind stall_watch_timers stw_checker #(.PRESC_W(PRESC_W), .LIMIT_W(LIMIT_W)) chk_i (.*);

// File: tb/stall_watch_timers_tb_top.sv
`timescale 1ns/1ps
module stall_watch_timers_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_en = 1'b0;
   logic [11:0] presc_val = '0;
   logic [11:0] limit_val = '0;
   logic        mem_act = 1'b0;
   logic        strm_act = 1'b0;
   logic        flag_clr = 1'b0;
   logic        mem_timeout;
   logic        strm_timeout;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   stall_watch_timers dut_i (.*);

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic prep(input logic [11:0] p, input logic [11:0] l);
      tmr_en = 1'b0; mem_act = 1'b0; strm_act = 1'b0;
      presc_val = p; limit_val = l;
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 mem", mem_timeout, 1'b0);
      check("R1 strm", strm_timeout, 1'b0);
   endtask

   task automatic t_expiry(input logic [11:0] p, input logic [11:0] l);
      int n;
      n = (int'(l) + 1) * (int'(p) + 1);
      prep(p, l);
      tmr_en = 1'b1;
      step(n - 1);
      check("R2/R3 mem early", mem_timeout, 1'b0);
      check("R2/R3 strm early", strm_timeout, 1'b0);
      step(1);
      check("R2/R3 mem at expiry", mem_timeout, 1'b1);
      check("R2/R3 strm at expiry", strm_timeout, 1'b1);
   endtask

   task automatic t_activity_and_sticky();
      prep(12'd0, 12'd5);
      tmr_en = 1'b1;
      for (int i = 0; i < 7; i++) begin
         step(2); mem_act = 1'b1; step(1); mem_act = 1'b0;
      end
      check("R4 mem held by activity", mem_timeout, 1'b0);
      check("R4 strm independent", strm_timeout, 1'b1);
      step(5);
      check("R4 mem before expiry", mem_timeout, 1'b0);
      step(1);
      check("R4 mem expires after restart", mem_timeout, 1'b1);
      mem_act = 1'b1; strm_act = 1'b1;
      step(10);
      check("R5 mem sticky", mem_timeout, 1'b1);
      check("R5 strm sticky", strm_timeout, 1'b1);
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      check("R5 mem cleared", mem_timeout, 1'b0);
      check("R5 strm cleared", strm_timeout, 1'b0);
      mem_act = 1'b0; strm_act = 1'b0;
   endtask

   task automatic t_disabled();
      prep(12'd0, 12'd0);
      step(50);
      check("R6 mem off", mem_timeout, 1'b0);
      check("R6 strm off", strm_timeout, 1'b0);
   endtask

   task automatic t_reenable();
      prep(12'd3, 12'd1);
      tmr_en = 1'b1; step(5);
      tmr_en = 1'b0; step(1);
      check("R6 no expiry before disable", mem_timeout, 1'b0);
      tmr_en = 1'b1;
      step(7);
      check("R7 mem not early after re-enable", mem_timeout, 1'b0);
      step(1);
      check("R7 mem full period after re-enable", mem_timeout, 1'b1);
   endtask

   task automatic t_clear_code();
      prep(12'd0, 12'hFFF);
      tmr_en = 1'b1;
      step(100);
      check("R8 mem no expiry on code", mem_timeout, 1'b0);
      check("R8 strm no expiry on code", strm_timeout, 1'b0);
      limit_val = 12'd5; step(4);
      limit_val = 12'hFFF; step(1);
      limit_val = 12'd2; step(2);
      check("R8 counters were cleared", mem_timeout, 1'b0);
      step(1);
      check("R8 expiry from zero", mem_timeout, 1'b1);
   endtask

   task automatic t_lower_limit();
      prep(12'd0, 12'd10);
      tmr_en = 1'b1; step(6);
      check("R9 not yet", strm_timeout, 1'b0);
      limit_val = 12'd2; step(1);
      check("R9 lowered limit expires next tick", strm_timeout, 1'b1);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_expiry(12'd0, 12'd3);
      t_expiry(12'd2, 12'd2);
      t_expiry(12'hFFF, 12'd0);
      t_activity_and_sticky();
      t_disabled();
      t_reenable();
      t_clear_code();
      t_lower_limit();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule